// File: doc/BRIEF.md
# Byte-Register SPI Master

This block is a host-side SPI master that software reaches through an eight-byte I/O window. Software sets up the transfer in two configuration bytes: a control byte and a mode/status byte. It then fills up to four data bytes. Writing the topmost data byte launches the frame. The block generates SCLK from the system clock and shifts the data bytes out on MOSI. At the same time it shifts the bits it samples on MISO back into the same bytes. It drives one of eight active-low select lines.

Software sets the frame length (8, 16, 24 or 32 bits), the SCLK idle level, the sampling edge, automatic or manual select, the clock divider, the bit order and an end-of-frame interrupt pulse. The status byte carries a BUSY flag that software polls. When BUSY clears, the received bits can be read back from the data bytes. With the control value 27h and the mode value 30h, a 24-bit MSB-first frame goes to device 7 at one quarter of the system clock.

Top module: `spi_regwin_master`

## Requirements
- R1: The window decodes as follows: offset 0 control, offset 1 mode/status, offsets 2, 3, 4 and 5 data bytes 0 to 3, offsets 6 and 7 read 00h. After reset, control reads 20h, mode/status reads 00h and every data byte reads 00h.
- R2: The control byte is laid out as follows: bits [2:0] hold the device index, bit 3 the SCLK idle level, bit 4 the sampling edge (0 rising, 1 falling), and bit 5 automatic select. Bits [7:6] set the frame length: 00 gives 24, 01 gives 8, 10 gives 16 and 11 gives 32 bits. A frame of N bytes uses data byte 3 and the N-1 bytes below it.
- R3: A write to offset 5 while idle starts a frame. Status bit 7 (BUSY) reads 1 from the next cycle until the frame ends. No other write starts a frame.
- R4: Mode bits [5:4] choose the SCLK period: 11 gives 4 system clocks, 10 gives 8, 01 gives 16 and 00 gives 32. With H as half that period, a frame of N bits keeps BUSY high for (2N+1)*H cycles and shows exactly 2N SCLK transitions.
- R5: When mode bit 2 is 0, the frame is sent MSB first, starting at bit 7 of data byte 3. When it is 1, the frame is sent LSB first, starting at bit 0 of the lowest byte in use.
- R6: The bits sampled on MISO replace the bits in use. With MSB first, the k-th bit received lands where the k-th bit sent came from, and the same holds with LSB first. Data bytes outside the frame keep their value.
- R7: SCLK rests at control bit 3 while idle. MOSI never changes on a sampling edge, so the first bit is valid before the first sampling edge in both phase relations.
- R8: With automatic select, the chosen line goes low for the frame and rises H cycles after the last SCLK transition. With bit 5 clear, the chosen line stays low whether or not a frame is running. Never more than one line is low.
- R9: While BUSY is 1, writes to any offset are ignored. A second write to offset 5 neither restarts nor extends the frame.
- R10: When mode bit 3 is 1, a one-cycle interrupt pulse coincides with the cycle in which BUSY falls. When it is 0, no pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (32 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Window offset for reads and writes |
| reg_wr | input | 1 | Write strobe, one cycle per byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed offset, combinational |
| miso_i | input | 1 | Serial data from the device |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the device |
| ss_n_o | output | NUM_SS | Active-low device selects |
| irq_o | output | 1 | End-of-frame pulse |

## Verification
If the edge counter or the length decoder goes wrong, the fault shows at the ports in one frame. BUSY then falls at the wrong cycle, the SCLK transition count differs from 2N, and the select line rises at the wrong distance from the last edge. If the shift window is wrong, the device model receives bits in the wrong order, and the readback after BUSY clears shows the fault in misplaced or overwritten bytes. If the phase logic is wrong, MOSI moves on a sampling edge, which a property on the serial pins catches within one half-period. Writes accepted during BUSY show up as a changed control readback or a frame of the wrong duration.

// File: rtl/spi_regwin_pkg.sv
`timescale 1ns/1ps
package spi_regwin_pkg;

   localparam int DATA_W = 32;
   localparam int BYTE_W = 8;
   localparam int WIN_AW = 3;

   localparam logic [WIN_AW-1:0] OFF_CTRL = 3'd0;
   localparam logic [WIN_AW-1:0] OFF_MODE = 3'd1;
   localparam logic [WIN_AW-1:0] OFF_D0   = 3'd2;
   localparam logic [WIN_AW-1:0] OFF_D1   = 3'd3;
   localparam logic [WIN_AW-1:0] OFF_D2   = 3'd4;
   localparam logic [WIN_AW-1:0] OFF_D3   = 3'd5;

   // control byte, MSB first: length code, auto select, edge, idle level, index
   typedef struct packed {
      logic [1:0] len;
      logic       auto_ss;
      logic       edge_fall;
      logic       cpol;
      logic [2:0] ss;
   } ctrl_t;

   // writable part of the mode byte (bits 5:2)
   typedef struct packed {
      logic [1:0] div;
      logic       irq_en;
      logic       lsb_first;
   } mode_t;

   localparam ctrl_t CTRL_RST = '{len: 2'b00, auto_ss: 1'b1, edge_fall: 1'b0,
                                  cpol: 1'b0, ss: 3'd0};

   function automatic logic [5:0] frame_bits(input logic [1:0] len);
      case (len)
         2'b01:   return 6'd8;
         2'b10:   return 6'd16;
         2'b11:   return 6'd32;
         default: return 6'd24;
      endcase
   endfunction

endpackage

// File: rtl/spi_regwin_regs.sv
`timescale 1ns/1ps
module spi_regwin_regs
   import spi_regwin_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [WIN_AW-1:0] addr_i,
   input  logic [BYTE_W-1:0] wdata_i,
   output logic [BYTE_W-1:0] rdata_o,
   input  logic              busy_i,
   input  logic              upd_en_i,
   input  logic [DATA_W-1:0] upd_val_i,
   output ctrl_t             ctrl_o,
   output mode_t             mode_o,
   output logic [DATA_W-1:0] data_o,
   output logic              start_o
);

   logic accept;
   assign accept  = wr_i & ~busy_i;
   assign start_o = accept && (addr_i == OFF_D3);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_o <= CTRL_RST;
         mode_o <= '0;
         data_o <= '0;
      end else if (upd_en_i) begin
         data_o <= upd_val_i;
      end else if (accept) begin
         case (addr_i)
            OFF_CTRL: ctrl_o         <= ctrl_t'(wdata_i);
            OFF_MODE: mode_o         <= mode_t'(wdata_i[5:2]);
            OFF_D0:   data_o[7:0]    <= wdata_i;
            OFF_D1:   data_o[15:8]   <= wdata_i;
            OFF_D2:   data_o[23:16]  <= wdata_i;
            OFF_D3:   data_o[31:24]  <= wdata_i;
            default:  ;
         endcase
      end
   end

   always_comb begin
      case (addr_i)
         OFF_CTRL: rdata_o = ctrl_o;
         OFF_MODE: rdata_o = {busy_i, 1'b0, mode_o, 2'b00};
         OFF_D0:   rdata_o = data_o[7:0];
         OFF_D1:   rdata_o = data_o[15:8];
         OFF_D2:   rdata_o = data_o[23:16];
         OFF_D3:   rdata_o = data_o[31:24];
         default:  rdata_o = '0;
      endcase
   end

endmodule

// File: rtl/spi_regwin_tick.sv
`timescale 1ns/1ps
module spi_regwin_tick #(
   parameter int DIV_MIN_LOG2 = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run_i,
   input  logic [1:0] div_i,
   output logic       tick_o
);

   localparam int HALF_MIN_LOG2 = DIV_MIN_LOG2 - 1;
   localparam int CNT_W         = HALF_MIN_LOG2 + 4;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] half_m1;

   // code 11 -> shortest half period, each lower code doubles it
   assign half_m1 = (CNT_W'(1) << (HALF_MIN_LOG2 + 3 - int'(div_i))) - CNT_W'(1);
   assign tick_o  = run_i && (cnt == half_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (!run_i) cnt <= '0;
      else if (tick_o) cnt <= '0;
      else             cnt <= cnt + CNT_W'(1);
   end

endmodule

// File: rtl/spi_regwin_engine.sv
`timescale 1ns/1ps
module spi_regwin_engine
   import spi_regwin_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              tick_i,
   input  ctrl_t             ctrl_i,
   input  mode_t             mode_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              miso_i,
   output logic              busy_o,
   output logic              sclk_o,
   output logic              mosi_o,
   output logic              done_o,
   output logic              upd_en_o,
   output logic [DATA_W-1:0] upd_val_o
);

   logic [6:0] ecnt;
   logic [6:0] ev;
   logic [6:0] last_ev;
   logic [5:0] nbits;
   logic [4:0] lo;
   logic       sclk_q;
   logic       samp_q;
   logic       lead_samples;
   logic       is_sample;
   logic       at_end;
   logic       step;

   assign nbits   = frame_bits(ctrl_i.len);
   assign lo      = 5'(6'(DATA_W) - nbits);
   assign ev      = ecnt + 7'd1;
   assign last_ev = {nbits, 1'b1};
   assign step    = busy_o && tick_i;
   assign at_end  = (ev == last_ev);

   // sampling on the leading edge when idle level and edge select agree
   assign lead_samples = (ctrl_i.cpol == ctrl_i.edge_fall);
   assign is_sample    = lead_samples ? ev[0] : ~ev[0];

   assign done_o   = step && at_end;
   assign upd_en_o = step && ((!at_end && !is_sample && (ev != 7'd1)) ||
                              (at_end && !lead_samples));

   always_comb begin
      upd_val_o = data_i;
      if (mode_i.lsb_first) begin
         for (int i = 0; i < DATA_W - 1; i++)
            if (i >= int'(lo)) upd_val_o[i] = data_i[i+1];
         upd_val_o[DATA_W-1] = samp_q;
      end else begin
         for (int i = 1; i < DATA_W; i++)
            if (i > int'(lo)) upd_val_o[i] = data_i[i-1];
         upd_val_o[lo] = samp_q;
      end
   end

   assign mosi_o = busy_o & (mode_i.lsb_first ? data_i[lo] : data_i[DATA_W-1]);
   assign sclk_o = busy_o ? sclk_q : ctrl_i.cpol;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         ecnt   <= '0;
         sclk_q <= 1'b0;
         samp_q <= 1'b0;
      end else if (start_i) begin
         busy_o <= 1'b1;
         ecnt   <= '0;
         sclk_q <= ctrl_i.cpol;
         samp_q <= 1'b0;
      end else if (step) begin
         ecnt <= ev;
         if (at_end) begin
            busy_o <= 1'b0;
         end else begin
            sclk_q <= ~sclk_q;
            if (is_sample) samp_q <= miso_i;
         end
      end
   end

endmodule

// File: rtl/spi_regwin_master.sv
`timescale 1ns/1ps
module spi_regwin_master
   import spi_regwin_pkg::*;
#(
   parameter int NUM_SS       = 8,
   parameter int DIV_MIN_LOG2 = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        reg_addr,
   input  logic              reg_wr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              miso_i,
   output logic              sclk_o,
   output logic              mosi_o,
   output logic [NUM_SS-1:0] ss_n_o,
   output logic              irq_o
);

   initial begin
      assert (NUM_SS >= 1 && NUM_SS <= 8)
         else $fatal(1, "NUM_SS must lie in 1..8");
      assert (DIV_MIN_LOG2 >= 1 && DIV_MIN_LOG2 <= 8)
         else $fatal(1, "DIV_MIN_LOG2 must lie in 1..8");
   end

   ctrl_t             ctrl;
   mode_t             mode;
   logic [DATA_W-1:0] data;
   logic [DATA_W-1:0] upd_val;
   logic              upd_en;
   logic              start;
   logic              busy;
   logic              tick;
   logic              done;
   logic              irq_q;

   spi_regwin_regs regs_i (
      .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr),
      .wdata_i(reg_wdata), .rdata_o(reg_rdata), .busy_i(busy),
      .upd_en_i(upd_en), .upd_val_i(upd_val), .ctrl_o(ctrl),
      .mode_o(mode), .data_o(data), .start_o(start)
   );

   spi_regwin_tick #(.DIV_MIN_LOG2(DIV_MIN_LOG2)) tick_i (
      .clk(clk), .rst_n(rst_n), .run_i(busy), .div_i(mode.div), .tick_o(tick)
   );

   spi_regwin_engine engine_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .tick_i(tick),
      .ctrl_i(ctrl), .mode_i(mode), .data_i(data), .miso_i(miso_i),
      .busy_o(busy), .sclk_o(sclk_o), .mosi_o(mosi_o), .done_o(done),
      .upd_en_o(upd_en), .upd_val_o(upd_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= done && mode.irq_en;
   end
   assign irq_o = irq_q;

   for (genvar g = 0; g < NUM_SS; g++) begin : g_sel
      assign ss_n_o[g] = ~((ctrl.ss == 3'(g)) && (ctrl.auto_ss ? busy : 1'b1));
   end

endmodule

// File: rtl/spi_regwin_chk.sv
`timescale 1ns/1ps
module spi_regwin_chk #(
   parameter int NUM_SS = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic [7:0]        ctrl,
   input logic [3:0]        mode,
   input logic              reg_wr,
   input logic [2:0]        reg_addr,
   input logic              sclk,
   input logic              mosi,
   input logic [NUM_SS-1:0] ss_n,
   input logic              irq
);

   // R3
   start_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(reg_wr && reg_addr == 3'd5));

   // R9
   cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(ctrl) && $stable(mode)));

   // R8
   one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~ss_n));

   // R8
   auto_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && ctrl[5]) |-> (&ss_n));

   // R7
   sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sclk == ctrl[3]));

   // R7
   mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && (sclk != $past(sclk)) && (sclk != ctrl[4]))
         |-> (mosi == $past(mosi)));

   // R10
   irq_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ($fell(busy) && mode[1]));

endmodule

bind spi_regwin_master spi_regwin_chk #(.NUM_SS(NUM_SS)) chk_i (
   .clk(clk), .rst_n(rst_n), .busy(busy), .ctrl(ctrl), .mode(mode),
   .reg_wr(reg_wr), .reg_addr(reg_addr), .sclk(sclk_o), .mosi(mosi_o),
   .ss_n(ss_n_o), .irq(irq_o)
);

// File: tb/spi_regwin_master_tb_top.sv
`timescale 1ns/1ps
module spi_regwin_master_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] reg_addr = '0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       miso = 1'b0;
   logic       sclk_o, mosi_o, irq_o;
   logic [7:0] ss_n_o;

   always #5 clk = ~clk;

   spi_regwin_master dut_i (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .miso_i(miso),
      .sclk_o(sclk_o), .mosi_o(mosi_o), .ss_n_o(ss_n_o), .irq_o(irq_o)
   );

   int checks = 0;
   int errors = 0;

   // device model state
   logic [2:0]  s_idx = 3'd0;
   bit          s_fall = 1'b0;
   logic [31:0] s_tx = '0;
   logic [31:0] s_rx = '0;
   int          s_k = 0;
   int          tog_cnt = 0;
   int          irq_cnt = 0;
   realtime     last_tog = 0;
   realtime     cs_rise = 0;
   logic        sel_n;
   assign sel_n = ss_n_o[s_idx];

   always @(sclk_o) begin
      tog_cnt++;
      last_tog = $realtime;
      if (!sel_n && (sclk_o == !s_fall) && s_k < 32) begin
         s_rx[s_k] = mosi_o;
         s_k++;
         if (s_k < 32) miso = s_tx[s_k];
      end
   end

   always @(posedge sel_n) cs_rise = $realtime;

   always @(negedge clk) if (rst_n && irq_o) irq_cnt++;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic rd_data(output logic [31:0] d);
      logic [7:0] b;
      for (int k = 0; k < 4; k++) begin
         rd(3'(2 + k), b);
         d[8*k +: 8] = b;
      end
   endtask

   function automatic logic [31:0] exp_window(input logic [31:0] d, input logic [31:0] tx,
                                              input int nb, input bit lsb);
      logic [31:0] r = d;
      int lo = 32 - 8*nb;
      for (int k = 0; k < 8*nb; k++) begin
         if (lsb) r[lo+k] = tx[k];
         else     r[31-k] = tx[k];
      end
      return r;
   endfunction

   function automatic logic [31:0] exp_sent(input logic [31:0] d, input int nb, input bit lsb);
      logic [31:0] r = '0;
      int lo = 32 - 8*nb;
      for (int k = 0; k < 8*nb; k++) r[k] = lsb ? d[lo+k] : d[31-k];
      return r;
   endfunction

   // loads registers, launches a frame and polls BUSY; poke writes during the frame
   task automatic run_frame(input logic [7:0] c, input logic [7:0] s,
                            input logic [31:0] d, input logic [31:0] tx, input bit poke,
                            output int cycles, output logic [7:0] ss_mid);
      wr(3'd0, c);
      wr(3'd1, s);
      wr(3'd2, d[7:0]);
      wr(3'd3, d[15:8]);
      wr(3'd4, d[23:16]);
      s_idx = c[2:0]; s_fall = c[4]; s_tx = tx; s_rx = '0; s_k = 0;
      miso = tx[0]; tog_cnt = 0; irq_cnt = 0;
      wr(3'd5, d[31:24]);
      cycles = 0;
      ss_mid = 8'h00;
      while (cycles < 5000) begin
         reg_addr = 3'd1;
         #1;
         if (!reg_rdata[7]) break;
         cycles++;
         if (cycles == 3) ss_mid = ss_n_o;
         if (poke && (cycles == 6 || cycles == 7)) begin
            reg_addr  = (cycles == 6) ? 3'd0 : 3'd5;
            reg_wdata = (cycles == 6) ? 8'h00 : 8'hFF;
            reg_wr    = 1'b1;
         end
         @(negedge clk);
         reg_wr = 1'b0;
      end
   endtask

   task automatic check_frame(input string tag, input logic [7:0] c, input logic [31:0] d,
                              input logic [31:0] tx, input int nb, input bit lsb,
                              input int half, input int cycles, input bit auto_cs);
      logic [31:0] got;
      chk(tag, "busy cycles R4", cycles, (16*nb + 1) * half);
      chk(tag, "sclk transitions R4", tog_cnt, 16*nb);
      chk(tag, "bits seen by device R2", s_k, 8*nb);
      chk(tag, "mosi bit order R5", s_rx, exp_sent(d, nb, lsb));
      rd_data(got);
      chk(tag, "received window R6", got, exp_window(d, tx, nb, lsb));
      if (auto_cs) begin
         chk(tag, "select release delay R8", 32'(int'(cs_rise - last_tog)), 32'(half * 10));
         chk(tag, "selects idle R8", ss_n_o, 8'hFF);
      end
      chk(tag, "sclk idle level R7", sclk_o, c[3]);
   endtask

   task automatic t_reset();
      logic [7:0] b;
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), b);
         chk("R1", $sformatf("reset read offset %0d", a), b, (a == 0) ? 8'h20 : 8'h00);
      end
      chk("R8", "selects after reset", ss_n_o, 8'hFF);
      chk("R7", "sclk after reset", sclk_o, 1'b0);
   endtask

   task automatic t_dac_word();
      int cyc; logic [7:0] mid;
      run_frame(8'h27, 8'h30, 32'h321230A5, 32'h5A3C96E1, 1'b0, cyc, mid);
      chk("R8", "device 7 selected mid-frame", mid, 8'h7F);
      check_frame("R3", 8'h27, 32'h321230A5, 32'h5A3C96E1, 3, 1'b0, 2, cyc, 1'b1);
      chk("R10", "no interrupt when disabled", irq_cnt, 0);
   endtask

   task automatic t_lsb16_falling();
      int cyc; logic [7:0] mid, b;
      run_frame(8'hBA, 8'h2C, 32'h9ABC1357, 32'h0000A6C3, 1'b0, cyc, mid);
      chk("R8", "device 2 selected mid-frame", mid, 8'hFB);
      check_frame("R5", 8'hBA, 32'h9ABC1357, 32'h0000A6C3, 2, 1'b1, 4, cyc, 1'b1);
      chk("R10", "one interrupt pulse", irq_cnt, 1);
      rd(3'd1, b);
      chk("R1", "mode readback", b, 8'h2C);
   endtask

   task automatic t_byte_trailing();
      int cyc; logic [7:0] mid;
      run_frame(8'h74, 8'h10, 32'hC6778899, 32'h0000004B, 1'b0, cyc, mid);
      chk("R8", "device 4 selected mid-frame", mid, 8'hEF);
      check_frame("R2", 8'h74, 32'hC6778899, 32'h0000004B, 1, 1'b0, 8, cyc, 1'b1);
   endtask

   task automatic t_manual_32();
      int cyc; logic [7:0] mid;
      wr(3'd0, 8'hC9);
      chk("R8", "manual select low while idle", ss_n_o, 8'hFD);
      run_frame(8'hC9, 8'h00, 32'h12345678, 32'hF0E1D2C3, 1'b0, cyc, mid);
      chk("R8", "manual select low mid-frame", mid, 8'hFD);
      check_frame("R4", 8'hC9, 32'h12345678, 32'hF0E1D2C3, 4, 1'b0, 16, cyc, 1'b0);
      chk("R8", "manual select held after frame", ss_n_o, 8'hFD);
      wr(3'd0, 8'h20);
      chk("R8", "select released on auto", ss_n_o, 8'hFF);
   endtask

   task automatic t_write_while_busy();
      int cyc; logic [7:0] mid, b;
      run_frame(8'h27, 8'h30, 32'h0F1E2D00, 32'h00A5F00F, 1'b1, cyc, mid);
      check_frame("R9", 8'h27, 32'h0F1E2D00, 32'h00A5F00F, 3, 1'b0, 2, cyc, 1'b1);
      rd(3'd0, b);
      chk("R9", "control unchanged by busy write", b, 8'h27);
   endtask

   initial begin
      #1_000_000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_dac_word();
      t_lsb16_falling();
      t_byte_trailing();
      t_manual_32();
      t_write_while_busy();
      repeat (4) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule